// File: doc/BRIEF.md
# Single-Channel PWM Timer with Staged Updates

This block generates one pulse-width-modulated output from two 32-bit word registers. The control word enables the channel, sets a prescale exponent and holds a staging flag. The count word holds a 10-bit period and a 10-bit high time. The input clock is divided by 2^N, where N can be 0 to 24. Each divided tick advances a 10-bit counter. The output goes high when a period starts and drops once the counter reaches the high-time value.

Software can change period, high time and prescale together without glitches. It raises the staging flag, writes the new values and then lowers the flag. While the flag is up, the new values land in shadow registers only. Lowering the flag commits them at the next period boundary, or in the next cycle if the channel is not running. While the flag is down, writes take effect at once. A zero period or a zero high time is illegal: the output stays low and the channel never starts. The output always starts a period high, so the block cannot produce a 0% duty cycle.

Top module: `pwm_timer_chan`

## Requirements
- R1: After reset, both registers read as zero and `pwm_o` is low.
- R2: The control word is at offset 0x0 and the count word at offset 0x4. In the control word: enable is bit 0, a stored mode bit is bit 4, the staging flag is bit 11, the exponent LSB is bit 15 and the exponent upper field is bits 19:16. In the count word: period is bits 25:16 and high time is bits 9:0. All other bits read as zero, and reads return the last written (shadow) values.
- R3: With period P and high time H (0 < H < P), the output has a period of P·2^N clocks and is high for the first H·2^N clocks of it. The first such period begins in the first cycle after the write that starts the channel.
- R4: N is formed as (upper field << 1) | LSB. Values of N above 24 act as 24.
- R5: If the active period or active high time is zero, `pwm_o` stays low even with enable set.
- R6: If H ≥ P, `pwm_o` stays high for the whole period.
- R7: While the staging flag is 1, count and prescale writes do not change the output. When the flag is cleared during operation, the staged values take effect from the first period boundary after the clearing write.
- R8: When the flag is cleared while the channel is not running, the staged values become active at once. The next start uses them.
- R9: Clearing enable drives `pwm_o` low in the next cycle and stops the counter. The next enable starts a fresh period from its beginning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| addr_i | input | 4 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| pwm_o | output | 1 | PWM output |

## Verification
Any error in the prescaler or the counter shows at `pwm_o` within one period. A wrong edge position moves the falling or rising edge by a multiple of 2^N clocks. A missed commit leaves the old period and high time visible past the first boundary after the staging flag is cleared. A commit made too early shows up before that boundary. Shadow-state errors show at once on the register readback.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int DW        = 32;
  localparam int CNT_W     = 10;
  localparam int PS_W      = 4;
  localparam int EXP_W     = PS_W + 1;
  localparam int MAX_EXP   = 24;

  localparam logic [3:0] OFS_CTRL = 4'h0;
  localparam logic [3:0] OFS_CNT  = 4'h4;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_BIT = 4;
  localparam int CTRL_SYNC_BIT = 11;
  localparam int CTRL_PLSB_BIT = 15;
  localparam int CTRL_PS_LSB   = 16;

  localparam int CNT_PER_LSB  = 16;
  localparam int CNT_HIGH_LSB = 0;
endpackage

// File: rtl/pwm_timer_regs.sv
module pwm_timer_regs
  import pwm_timer_pkg::*;
#(
  parameter int AW     = 4,
  parameter int CW     = CNT_W,
  parameter int PW     = PS_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            run_i,
  input  logic            wrap_i,
  output logic [DW-1:0]   rdata_o,
  output logic            en_o,
  output logic            sync_o,
  output logic [CW-1:0]   act_per_o,
  output logic [CW-1:0]   act_high_o,
  output logic [PW:0]     act_exp_o
);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);
  localparam logic [AW-1:0] A_CNT  = AW'(OFS_CNT);

  logic          en_q, mode_q, sync_q, pend_q;
  logic [CW-1:0] shd_per_q, shd_high_q, act_per_q, act_high_q;
  logic [PW-1:0] shd_ps_q, act_ps_q;
  logic          shd_lsb_q, act_lsb_q;

  logic wr_ctrl, wr_cnt, sync_fall, commit;

  assign wr_ctrl   = wr_i & (addr_i == A_CTRL);
  assign wr_cnt    = wr_i & (addr_i == A_CNT);
  assign sync_fall = wr_ctrl & sync_q & ~wdata_i[CTRL_SYNC_BIT];
  // commit waits for a period boundary unless the channel is idle
  assign commit    = pend_q & ~sync_q & (~run_i | wrap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      mode_q     <= 1'b0;
      sync_q     <= 1'b0;
      pend_q     <= 1'b0;
      shd_per_q  <= '0;
      shd_high_q <= '0;
      shd_ps_q   <= '0;
      shd_lsb_q  <= 1'b0;
      act_per_q  <= '0;
      act_high_q <= '0;
      act_ps_q   <= '0;
      act_lsb_q  <= 1'b0;
    end else begin
      if (commit) begin
        act_per_q  <= shd_per_q;
        act_high_q <= shd_high_q;
        act_ps_q   <= shd_ps_q;
        act_lsb_q  <= shd_lsb_q;
        pend_q     <= 1'b0;
      end
      if (sync_fall) pend_q <= 1'b1;
      if (wr_ctrl) begin
        en_q      <= wdata_i[CTRL_EN_BIT];
        mode_q    <= wdata_i[CTRL_MODE_BIT];
        sync_q    <= wdata_i[CTRL_SYNC_BIT];
        shd_lsb_q <= wdata_i[CTRL_PLSB_BIT];
        shd_ps_q  <= wdata_i[CTRL_PS_LSB +: PW];
        if (!sync_q) begin
          act_lsb_q <= wdata_i[CTRL_PLSB_BIT];
          act_ps_q  <= wdata_i[CTRL_PS_LSB +: PW];
        end
      end
      if (wr_cnt) begin
        shd_per_q  <= wdata_i[CNT_PER_LSB +: CW];
        shd_high_q <= wdata_i[CNT_HIGH_LSB +: CW];
        if (!sync_q) begin
          act_per_q  <= wdata_i[CNT_PER_LSB +: CW];
          act_high_q <= wdata_i[CNT_HIGH_LSB +: CW];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) begin
      rdata_o[CTRL_EN_BIT]         = en_q;
      rdata_o[CTRL_MODE_BIT]       = mode_q;
      rdata_o[CTRL_SYNC_BIT]       = sync_q;
      rdata_o[CTRL_PLSB_BIT]       = shd_lsb_q;
      rdata_o[CTRL_PS_LSB +: PW]   = shd_ps_q;
    end else if (addr_i == A_CNT) begin
      rdata_o[CNT_PER_LSB +: CW]   = shd_per_q;
      rdata_o[CNT_HIGH_LSB +: CW]  = shd_high_q;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign en_o       = en_q;
  assign sync_o     = sync_q;
  assign act_per_o  = act_per_q;
  assign act_high_o = act_high_q;
  assign act_exp_o  = {act_ps_q, act_lsb_q};
endmodule

// File: rtl/pwm_timer_prescaler.sv
module pwm_timer_prescaler #(
  parameter int EW      = 5,
  parameter int MAX_E   = 24
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [EW-1:0] exp_i,
  output logic          tick_o
);
  localparam int PRE_W = (MAX_E > 0) ? MAX_E : 1;
  localparam logic [EW-1:0] E_LIM = EW'(MAX_E);

  logic [EW-1:0]    exp_c;
  logic [PRE_W-1:0] mask, pre_q;

  assign exp_c = (exp_i > E_LIM) ? E_LIM : exp_i;

  generate
    if (MAX_E == 0) begin : g_nodiv
      assign mask = '0;
    end else begin : g_div
      for (genvar i = 0; i < PRE_W; i++) begin : g_bit
        assign mask[i] = (EW'(i) < exp_c);
      end
    end
  endgenerate

  assign tick_o = run_i & (pre_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (!run_i)  pre_q <= '0;
    else if (tick_o)  pre_q <= '0;
    else              pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/pwm_timer_counter.sv
module pwm_timer_counter #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] high_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o,
  output logic          pwm_o
);
  logic [CW-1:0] cnt_q;

  assign wrap_o = tick_i & (cnt_q == per_i - CW'(1));
  // high >= period keeps the compare true for the whole period
  assign pwm_o  = run_i & (cnt_q < high_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!run_i)  cnt_q <= '0;
    else if (wrap_o)  cnt_q <= '0;
    else if (tick_i)  cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
  import pwm_timer_pkg::*;
#(
  parameter int AW    = 4,
  parameter int CW    = CNT_W,
  parameter int PW    = PS_W,
  parameter int MAX_E = MAX_EXP
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          pwm_o
);
  localparam int EW = PW + 1;

  logic          en, sync, run, tick, wrap;
  logic [CW-1:0] act_per, act_high, cnt;
  logic [EW-1:0] act_exp;

  assign run = en & (|act_per) & (|act_high);

  pwm_timer_regs #(.AW(AW), .CW(CW), .PW(PW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .run_i      (run),
    .wrap_i     (wrap),
    .rdata_o    (rdata_o),
    .en_o       (en),
    .sync_o     (sync),
    .act_per_o  (act_per),
    .act_high_o (act_high),
    .act_exp_o  (act_exp)
  );

  pwm_timer_prescaler #(.EW(EW), .MAX_E(MAX_E)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .exp_i  (act_exp),
    .tick_o (tick)
  );

  pwm_timer_counter #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_i (tick),
    .per_i  (act_per),
    .high_i (act_high),
    .cnt_o  (cnt),
    .wrap_o (wrap),
    .pwm_o  (pwm_o)
  );
endmodule

// File: rtl/pwm_timer_chan_chk.sv
module pwm_timer_chan_chk #(
  parameter int CW = 10,
  parameter int EW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          run_i,
  input logic          sync_i,
  input logic [CW-1:0] cnt_i,
  input logic [CW-1:0] per_i,
  input logic [CW-1:0] high_i,
  input logic [EW-1:0] exp_i,
  input logic          pwm_i
);
  p_off_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !pwm_i);

  p_zero_blocks_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_i == '0 || high_i == '0) |-> !pwm_i);

  p_cnt_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_i < per_i));

  p_start_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && cnt_i == '0) |-> pwm_i);

  p_full_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && high_i >= per_i) |-> pwm_i);

  p_staged_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |=> $stable({per_i, high_i, exp_i}));

  p_fresh_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (cnt_i == '0));
endmodule

bind pwm_timer_chan pwm_timer_chan_chk #(.CW(CW), .EW(EW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .run_i  (run),
  .sync_i (sync),
  .cnt_i  (cnt),
  .per_i  (act_per),
  .high_i (act_high),
  .exp_i  (act_exp),
  .pwm_i  (pwm_o)
);

// File: tb/pwm_timer_chan_tb.sv
module pwm_timer_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pwm;

  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pwm_timer_chan u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .wr_i    (wr),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata),
    .pwm_o   (pwm)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr_reg(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic logic [31:0] ctrl_w(int en, int sync, int n);
    return 32'(en & 1) | (32'(sync & 1) << 11) | (32'(n & 1) << 15) | (32'((n >> 1) & 15) << 16);
  endfunction

  function automatic logic [31:0] cnt_w(int p, int h);
    return (32'(p & 1023) << 16) | 32'(h & 1023);
  endfunction

  function automatic logic exp_pwm(int k, int p, int h, int n);
    int per;
    int hi;
    per = p << n;
    hi  = ((h >= p) ? p : h) << n;
    return (k % per) < hi;
  endfunction

  task automatic check_wave(string req, int t0, int p, int h, int n, int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      check(req, 32'(pwm), 32'(exp_pwm(cyc - t0, p, h, n)));
      @(negedge clk);
    end
  endtask

  task automatic check_low(string req, int ncyc);
    for (int i = 0; i < ncyc; i++) begin
      check(req, 32'(pwm), 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int t0, tc, m;
    void'($urandom(32'h1bad5eed));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_reg(4'h0, d); check("R1 ctrl", d, 32'h0);
    rd_reg(4'h4, d); check("R1 cnt", d, 32'h0);
    check("R1 pwm", 32'(pwm), 32'h0);

    // R2 field layout and reserved bits
    wr_reg(4'h0, 32'hFFFF_FFFF);
    rd_reg(4'h0, d); check("R2 ctrl mask", d, 32'h000F_8811);
    wr_reg(4'h4, 32'hFFFF_FFFF);
    rd_reg(4'h4, d); check("R2 cnt mask", d, 32'h03FF_03FF);
    rd_reg(4'h8, d); check("R2 unmapped", d, 32'h0);
    wr_reg(4'h0, 32'h0);
    rd_reg(4'h0, d); check("R2 ctrl clear", d, 32'h0);

    // R3 directed, N=0
    wr_reg(4'h4, cnt_w(5, 2));
    wr_reg(4'h0, ctrl_w(1, 0, 0));
    t0 = cyc;
    check_wave("R3 p5h2", t0, 5, 2, 0, 12);

    // R4 exponent from field and lsb: N=3 (field 1, lsb 1), N=2 (field 1, lsb 0)
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h4, cnt_w(3, 1));
    wr_reg(4'h0, ctrl_w(1, 0, 3));
    t0 = cyc;
    check_wave("R4 n3", t0, 3, 1, 3, 30);
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h0, ctrl_w(1, 0, 2));
    t0 = cyc;
    check_wave("R4 n2", t0, 3, 1, 2, 15);
    // R4 N=31 acts as 24: high for a very long first tick
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h4, cnt_w(2, 1));
    wr_reg(4'h0, ctrl_w(1, 0, 31));
    check_wave("R4 clamp", cyc, 2, 1, 24, 50);

    // R5 zero period, then zero high time
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h4, cnt_w(0, 5));
    wr_reg(4'h0, ctrl_w(1, 0, 0));
    check_low("R5 zero period", 20);
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h4, cnt_w(5, 0));
    wr_reg(4'h0, ctrl_w(1, 0, 0));
    check_low("R5 zero high", 20);

    // R6 high >= period
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h4, cnt_w(5, 9));
    wr_reg(4'h0, ctrl_w(1, 0, 1));
    check_wave("R6 h>p", cyc, 5, 9, 1, 30);
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h4, cnt_w(4, 4));
    wr_reg(4'h0, ctrl_w(1, 0, 0));
    check_wave("R6 h=p", cyc, 4, 4, 0, 12);

    // R9 disable, then fresh start
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h4, cnt_w(5, 2));
    wr_reg(4'h0, ctrl_w(1, 0, 1));
    t0 = cyc;
    check_wave("R9 pre", t0, 5, 2, 1, 7);
    wr_reg(4'h0, ctrl_w(0, 0, 1));
    check_low("R9 off", 5);
    wr_reg(4'h0, ctrl_w(1, 0, 1));
    t0 = cyc;
    check_wave("R9 restart", t0, 5, 2, 1, 25);

    // R7 staged update while running
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h4, cnt_w(4, 1));
    wr_reg(4'h0, ctrl_w(1, 0, 0));
    t0 = cyc;
    check_wave("R7 old", t0, 4, 1, 0, 6);
    wr_reg(4'h0, ctrl_w(1, 1, 0));
    wr_reg(4'h4, cnt_w(6, 3));
    rd_reg(4'h4, d); check("R7 shadow readback", d, cnt_w(6, 3));
    check_wave("R7 staged", t0, 4, 1, 0, 9);
    wr_reg(4'h0, ctrl_w(1, 0, 0));
    tc = cyc - t0;
    m = ((tc / 4) + 1) * 4;
    for (int i = 0; i < 30; i++) begin
      int k;
      k = cyc - t0;
      check("R7 commit", 32'(pwm),
            32'((k < m) ? exp_pwm(k, 4, 1, 0) : exp_pwm(k - m, 6, 3, 0)));
      @(negedge clk);
    end

    // R8 commit while stopped
    wr_reg(4'h0, 32'h0);
    wr_reg(4'h0, ctrl_w(0, 1, 0));
    wr_reg(4'h4, cnt_w(3, 2));
    wr_reg(4'h0, ctrl_w(0, 0, 0));
    wr_reg(4'h0, ctrl_w(1, 0, 0));
    check_wave("R8 idle commit", cyc, 3, 2, 0, 12);

    // R3 random configurations
    for (int it = 0; it < 14; it++) begin
      int p, h, n;
      p = 1 + int'($urandom % 20);
      h = 1 + int'($urandom % 24);
      n = int'($urandom % 4);
      wr_reg(4'h0, 32'h0);
      check("R9 off before cfg", 32'(pwm), 32'h0);
      wr_reg(4'h4, cnt_w(p, h));
      wr_reg(4'h0, ctrl_w(1, 0, n));
      t0 = cyc;
      check_wave((h >= p) ? "R6 random" : "R3 random", t0, p, h, n, 2 * (p << n) + 3);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule